// File: doc/BRIEF.md
# Serial NAND Cached Page Reader

This block fetches a run of bytes from a serial NAND flash over a four-wire serial bus (SPI mode 0). A request carries a byte address, a length and a bad-block flag. The reader splits the address into a page row and a column. It moves the page from the flash array into the on-die cache and polls the status register until the device is no longer busy. It then decodes the ECC result and streams the requested bytes out of the cache through a valid/ready byte port. A read that runs past the end of a page continues at column 0 of the following row, and that row gets its own page load.

The reader keeps the row it last moved into the cache. A later request, or the next page of the same request, that needs that row skips the array-to-cache step and goes straight to the cache read. The remembered row is dropped after an uncorrectable ECC result, after a poll timeout, and whenever the `flush` input reports that an erase or program has changed the array elsewhere. Each request ends with a one-cycle `done` pulse that carries a result code.

Top module: `nand_page_reader`

## Requirements
- R1: The address is split into row = addr >> 11 and column = addr[10:0]. A page load sends command 0x13 and then the row as three bytes, most significant first.
- R2: After a page load the reader sends 0x0F, 0xC0 and one further byte, and samples the status byte. It repeats this while status bit 0 is set. When POLL_MAX status reads (default 200) have all returned busy, it ends with status 3 (timeout) and delivers no bytes.
- R3: Status bits [5:4] hold the ECC result. The value 1 lets the data flow and ends the request with status 1 (corrected). The value 2 ends it with status 2 (uncorrectable) and delivers no bytes.
- R4: A cache read sends 0x03, the column as two bytes (most significant first) and one dummy byte, then clocks in data. The bytes reach `out_data` in address order.
- R5: When the row needed equals the last row loaded, the page load and status polling are skipped.
- R6: The remembered row is forgotten after an uncorrectable result, after a timeout, or in a cycle where `flush` is high. Flush takes priority over a fill in the same cycle. The next read of that row then reloads the page. Row 0xFFFF can be remembered like any other row.
- R7: A read that reaches column 2047 continues at column 0 of the next row, and that row is handled as a new page.
- R8: If a page load is needed and `req_bad` was set, the request ends with status 4, and `spi_cs_n` is not driven low. A request whose rows are all already cached ignores `req_bad`.
- R9: A request with addr + len > 2^27 ends with status 5, and `spi_cs_n` stays high. A request that ends exactly at 2^27 is served.
- R10: A request of length 0 ends with status 0 and delivers no bytes, and `spi_cs_n` stays high.
- R11: `out_data` stays stable while `out_valid` is high and `out_ready` is low. `req_ready` is high only while idle. `done` is high for one cycle, after the last byte has been accepted, and never together with `out_valid`.
- R12: After reset `req_ready` is 1, and `spi_cs_n` is 1, `out_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Reader idle and able to take a request |
| req_addr | input | 27 | Start byte address |
| req_len | input | 16 | Number of bytes to read |
| req_bad | input | 1 | Request targets a block known to be bad |
| flush | input | 1 | Forget the remembered row (array changed) |
| out_data | output | 8 | Data byte |
| out_valid | output | 1 | Data byte present |
| out_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 3 | Result: 0 ok, 1 corrected, 2 uncorrectable, 3 timeout, 4 bad block, 5 out of range |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The main read path is tried in several ways: a short read in the middle of a page, a second read of the same page, a read that crosses a page boundary, and a crossing read with a consumer that stalls two cycles out of three. Counting page loads at the flash model separates a cached hit from a reload. The consumer stalls show whether the byte order and data hold up under backpressure. Status replies then vary the ECC field (1 and 2) and the number of busy polls (199 busy reads against 250), which tells corrected, uncorrectable, just-in-time and timed-out loads apart. The chip-select edge count shows that bad-block, out-of-range and zero-length requests never touch the bus, and a request ending exactly at the last device byte checks both the range limit and the caching of the all-ones row.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

   typedef enum logic [2:0] {
      ST_OK     = 3'd0,
      ST_CORR   = 3'd1,
      ST_UNCORR = 3'd2,
      ST_TMO    = 3'd3,
      ST_BAD    = 3'd4,
      ST_RANGE  = 3'd5
   } rd_status_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CHECK, S_LOAD, S_GAP, S_POLL, S_EVAL,
      S_RDHDR, S_RDDATA, S_OUT, S_DONE
   } rd_state_e;

   localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
   localparam logic [7:0] OP_GET_REG   = 8'h0F;
   localparam logic [7:0] REG_STATUS   = 8'hC0;
   localparam logic [7:0] OP_CACHE_RD  = 8'h03;
   localparam logic [7:0] FILL_BYTE    = 8'h00;

endpackage

// File: rtl/nand_spi_byte.sv
module nand_spi_byte #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] tx,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rx,
   output logic         sclk,
   output logic         mosi,
   input  logic         miso
);
   localparam int CW = $clog2(W);

   if (W < 2) begin : g_bad_w
      $error("nand_spi_byte: W must be at least 2");
   end

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;
   logic          ph_q, busy_q, done_q, sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            sh_q   <= tx;
            cnt_q  <= '0;
            ph_q   <= 1'b0;
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
         end else if (busy_q) begin
            if (!ph_q) begin
               ph_q   <= 1'b1;
               sclk_q <= 1'b1;
            end else begin
               ph_q   <= 1'b0;
               sclk_q <= 1'b0;
               sh_q   <= {sh_q[W-2:0], miso};
               if (cnt_q == CW'(W-1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign rx   = sh_q;
   assign sclk = sclk_q;
   assign mosi = sh_q[W-1];

   // R4: a byte is only launched on an idle shifter
   p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);
   // R4: clock high only inside a transfer
   p_sclk_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> busy_q);

endmodule

// File: rtl/nand_row_cache.sv
module nand_row_cache #(
   parameter int ROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fill,
   input  logic [ROW_W-1:0] fill_row,
   input  logic [ROW_W-1:0] query_row,
   output logic             hit
);
   // one extra bit so that the all-ones marker never equals a real row
   logic [ROW_W:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tag_q <= '1;
      else if (flush) tag_q <= '1;
      else if (fill)  tag_q <= {1'b0, fill_row};
   end

   assign hit = (tag_q == {1'b0, query_row});

   // R6: after a flush no row is reported as cached
   p_flush_forgets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);
   // R5: a fill makes that same row hit next cycle when queried
   p_fill_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && !flush && fill_row == query_row) |=> ($stable(query_row) -> hit));

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
   import nand_rd_pkg::*;
#(
   parameter int PAGE_BYTES    = 2048,
   parameter int PAGES_PER_BLK = 64,
   parameter int BLOCKS        = 1024,
   parameter int LEN_W         = 16,
   parameter int POLL_MAX      = 200,
   parameter bit CHECK_RANGE   = 1'b1,
   localparam int COL_W  = $clog2(PAGE_BYTES),
   localparam int ROW_W  = $clog2(PAGES_PER_BLK) + $clog2(BLOCKS),
   localparam int ADDR_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_bad,
   input  logic              flush,
   output logic [7:0]        out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              done,
   output logic [2:0]        status,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int POLL_W = $clog2(POLL_MAX + 1);
   localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

   if ((1 << COL_W) != PAGE_BYTES || COL_W > 16) begin : g_bad_page
      $error("nand_page_reader: PAGE_BYTES must be a power of two up to 65536");
   end
   if (ROW_W > 24 || (1 << ROW_W) != PAGES_PER_BLK * BLOCKS) begin : g_bad_row
      $error("nand_page_reader: row must be a power of two of at most 24 bits");
   end
   if (LEN_W > ADDR_W || POLL_MAX < 1) begin : g_bad_misc
      $error("nand_page_reader: LEN_W or POLL_MAX out of range");
   end

   rd_state_e          state;
   rd_status_e         status_q;
   logic               cs_n_q, bstart, bdone, bbusy, bad_q, corr_q, ov_q, hit, over;
   logic [7:0]         btx, brx, od_q;
   logic [1:0]         bidx;
   logic [ROW_W-1:0]   row_q;
   logic [COL_W-1:0]   col_q;
   logic [LEN_W-1:0]   rem_q;
   logic [POLL_W-1:0]  polls_q;
   logic [2:0]         st_q;      // {ecc[1:0], busy}
   logic               eval_ok, eval_kill;

   // ---------------- request range check (variant chosen by parameter)
   if (CHECK_RANGE) begin : g_range
      localparam logic [ADDR_W+1:0] DEV_END = (ADDR_W+2)'(1) << ADDR_W;
      logic [ADDR_W+1:0] end_pos;
      assign end_pos = (ADDR_W+2)'(req_addr) + (ADDR_W+2)'(req_len);
      assign over    = end_pos > DEV_END;
   end else begin : g_no_range
      assign over = 1'b0;
   end

   // ---------------- byte stream of each command
   function automatic logic [7:0] cmd_byte(rd_state_e s, logic [1:0] i,
                                           logic [23:0] r, logic [15:0] c);
      logic [7:0] b;
      b = FILL_BYTE;
      case (s)
         S_LOAD:  case (i)
                     2'd0: b = OP_PAGE_LOAD;
                     2'd1: b = r[23:16];
                     2'd2: b = r[15:8];
                     default: b = r[7:0];
                  endcase
         S_POLL:  case (i)
                     2'd0: b = OP_GET_REG;
                     2'd1: b = REG_STATUS;
                     default: b = FILL_BYTE;
                  endcase
         S_RDHDR: case (i)
                     2'd0: b = OP_CACHE_RD;
                     2'd1: b = c[15:8];
                     2'd2: b = c[7:0];
                     default: b = FILL_BYTE;
                  endcase
         default: b = FILL_BYTE;
      endcase
      return b;
   endfunction

   logic [23:0] row24;
   logic [15:0] col16;
   assign row24 = 24'(row_q);
   assign col16 = 16'(col_q);

   // ---------------- cache bookkeeping of the last loaded row
   assign eval_ok   = (state == S_EVAL) && !st_q[0] && (st_q[2:1] != 2'd2);
   assign eval_kill = (state == S_EVAL) &&
                      ((st_q[0] && polls_q == POLL_LAST) || (!st_q[0] && st_q[2:1] == 2'd2));

   nand_row_cache #(.ROW_W(ROW_W)) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush || eval_kill),
      .fill      (eval_ok),
      .fill_row  (row_q),
      .query_row (row_q),
      .hit       (hit)
   );

   nand_spi_byte #(.W(8)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bstart),
      .tx    (btx),
      .busy  (bbusy),
      .done  (bdone),
      .rx    (brx),
      .sclk  (spi_sclk),
      .mosi  (spi_mosi),
      .miso  (spi_miso)
   );

   // ---------------- sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         status_q <= ST_OK;
         cs_n_q   <= 1'b1;
         bstart   <= 1'b0;
         btx      <= '0;
         bidx     <= '0;
         row_q    <= '0;
         col_q    <= '0;
         rem_q    <= '0;
         bad_q    <= 1'b0;
         corr_q   <= 1'b0;
         polls_q  <= '0;
         st_q     <= '0;
         od_q     <= '0;
         ov_q     <= 1'b0;
      end else begin
         bstart <= 1'b0;
         unique case (state)
            S_IDLE: if (req_valid) begin
               row_q  <= req_addr[ADDR_W-1:COL_W];
               col_q  <= req_addr[COL_W-1:0];
               rem_q  <= req_len;
               bad_q  <= req_bad;
               corr_q <= 1'b0;
               if (over) begin
                  status_q <= ST_RANGE;
                  state    <= S_DONE;
               end else if (req_len == '0) begin
                  status_q <= ST_OK;
                  state    <= S_DONE;
               end else begin
                  state <= S_CHECK;
               end
            end
            S_CHECK: if (hit) begin
               cs_n_q <= 1'b0; bidx <= '0; bstart <= 1'b1;
               btx    <= cmd_byte(S_RDHDR, 2'd0, row24, col16);
               state  <= S_RDHDR;
            end else if (bad_q) begin
               status_q <= ST_BAD;
               state    <= S_DONE;
            end else begin
               cs_n_q <= 1'b0; bidx <= '0; bstart <= 1'b1;
               btx    <= cmd_byte(S_LOAD, 2'd0, row24, col16);
               state  <= S_LOAD;
            end
            S_LOAD: if (bdone) begin
               if (bidx == 2'd3) begin
                  cs_n_q  <= 1'b1;
                  polls_q <= '0;
                  state   <= S_GAP;
               end else begin
                  bidx   <= bidx + 1'b1;
                  bstart <= 1'b1;
                  btx    <= cmd_byte(S_LOAD, 2'(bidx + 1'b1), row24, col16);
               end
            end
            S_GAP: begin
               cs_n_q <= 1'b0; bidx <= '0; bstart <= 1'b1;
               btx    <= cmd_byte(S_POLL, 2'd0, row24, col16);
               state  <= S_POLL;
            end
            S_POLL: if (bdone) begin
               if (bidx == 2'd2) begin
                  st_q   <= {brx[5:4], brx[0]};
                  cs_n_q <= 1'b1;
                  state  <= S_EVAL;
               end else begin
                  bidx   <= bidx + 1'b1;
                  bstart <= 1'b1;
                  btx    <= cmd_byte(S_POLL, 2'(bidx + 1'b1), row24, col16);
               end
            end
            S_EVAL: if (st_q[0]) begin
               if (polls_q == POLL_LAST) begin
                  status_q <= ST_TMO;
                  state    <= S_DONE;
               end else begin
                  polls_q <= polls_q + 1'b1;
                  cs_n_q  <= 1'b0; bidx <= '0; bstart <= 1'b1;
                  btx     <= cmd_byte(S_POLL, 2'd0, row24, col16);
                  state   <= S_POLL;
               end
            end else if (st_q[2:1] == 2'd2) begin
               status_q <= ST_UNCORR;
               state    <= S_DONE;
            end else begin
               corr_q <= corr_q | (st_q[2:1] == 2'd1);
               cs_n_q <= 1'b0; bidx <= '0; bstart <= 1'b1;
               btx    <= cmd_byte(S_RDHDR, 2'd0, row24, col16);
               state  <= S_RDHDR;
            end
            S_RDHDR: if (bdone) begin
               bstart <= 1'b1;
               if (bidx == 2'd3) begin
                  btx   <= FILL_BYTE;
                  state <= S_RDDATA;
               end else begin
                  bidx <= bidx + 1'b1;
                  btx  <= cmd_byte(S_RDHDR, 2'(bidx + 1'b1), row24, col16);
               end
            end
            S_RDDATA: if (bdone) begin
               od_q  <= brx;
               ov_q  <= 1'b1;
               state <= S_OUT;
            end
            S_OUT: if (out_ready) begin
               ov_q  <= 1'b0;
               rem_q <= rem_q - 1'b1;
               col_q <= col_q + 1'b1;
               if (rem_q == LEN_W'(1)) begin
                  cs_n_q   <= 1'b1;
                  status_q <= corr_q ? ST_CORR : ST_OK;
                  state    <= S_DONE;
               end else if (col_q == '1) begin
                  cs_n_q <= 1'b1;
                  row_q  <= row_q + 1'b1;
                  state  <= S_CHECK;
               end else begin
                  bstart <= 1'b1;
                  btx    <= FILL_BYTE;
                  state  <= S_RDDATA;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (state == S_IDLE);
   assign done      = (state == S_DONE);
   assign status    = status_q;
   assign out_data  = od_q;
   assign out_valid = ov_q;
   assign spi_cs_n  = cs_n_q;

   // R4: serial clock only toggles with the device selected
   p_sclk_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n);
   // R11: bus is quiet whenever a new request may be taken
   p_idle_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> spi_cs_n);
   // R11: a stalled byte is held
   p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R11: completion never overlaps a pending byte
   p_done_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);
   // R2: the poll counter never passes its limit
   p_poll_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      polls_q <= POLL_LAST);
   // R4: the sequencer never launches into a running shifter
   p_launch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bstart |-> !bbusy);

endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [26:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        req_bad = 1'b0;
   logic        flush = 1'b0;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        done;
   logic [2:0]  status;
   logic        spi_cs_n, spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nand_page_reader u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_bad(req_bad), .flush(flush),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .done(done), .status(status), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int nchk = 0, nerr = 0;
   string cur_tag = "";

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(int row, int col);
      return 8'((row * 13) + (col * 7) + (col >> 8));
   endfunction

   // ---------------- flash model
   int         bitc = 0, busy_left = 0, busy_cfg = 3, loads = 0, cs_falls = 0;
   logic [1:0] ecc_cfg = 2'd0, ecc_now = 2'd0;
   logic [7:0] msh = '0;
   logic [7:0] hdr [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
   int         mrow = 0;

   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         if (bitc >= 32 && hdr[0] == 8'h13) begin
            mrow      = {hdr[1], hdr[2], hdr[3]};
            loads     = loads + 1;
            busy_left = busy_cfg;
            ecc_now   = ecc_cfg;
         end else if (bitc >= 24 && hdr[0] == 8'h0F && busy_left > 0) begin
            busy_left = busy_left - 1;
         end
         bitc = 0;
      end else begin
         msh = {msh[6:0], spi_mosi};
         if (bitc % 8 == 7 && bitc < 32) hdr[bitc / 8] = msh;
         bitc = bitc + 1;
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         if (hdr[0] == 8'h0F && hdr[1] == 8'hC0 && bitc >= 16) begin
            automatic int k = bitc - 16;
            automatic logic [7:0] st = {2'b00, ecc_now, 3'b000, (busy_left > 0)};
            spi_miso <= st[7 - k % 8];
         end else if (hdr[0] == 8'h03 && bitc >= 32) begin
            automatic int k = bitc - 32;
            automatic logic [7:0] b = pat(mrow, int'({hdr[1], hdr[2]}) + k / 8);
            spi_miso <= b[7 - k % 8];
         end
      end
   end

   always @(negedge spi_cs_n) if (rst_n) cs_falls = cs_falls + 1;

   // ---------------- scoreboard
   logic [7:0] exp_q [$];
   bit   stall_mode = 1'b0, prev_stall = 1'b0;
   logic [7:0] prev_data = '0;
   int   cyc = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_stall) begin
            chk(out_valid && out_data == prev_data, "R11", "held byte",
                int'(out_data), int'(prev_data));
         end
         out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected byte", int'(out_data), -1);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               chk(out_data == e, cur_tag, "data byte", int'(out_data), int'(e));
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   task automatic do_read(int addr, int len, bit bad, int exp_st, int exp_loads,
                          bit exp_bus, string tag);
      int l0, f0;
      cur_tag = tag;
      if (exp_st <= 1)
         for (int i = 0; i < len; i++) exp_q.push_back(pat((addr + i) >> 11, (addr + i) & 2047));
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      l0 = loads; f0 = cs_falls;
      req_addr = 27'(addr); req_len = 16'(len); req_bad = bad; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(int'(status) == exp_st, tag, "status", int'(status), exp_st);
      chk(exp_q.size() == 0, tag, "bytes left undelivered", exp_q.size(), 0);
      chk(loads - l0 == exp_loads, tag, "page loads", loads - l0, exp_loads);
      if (!exp_bus) chk(cs_falls == f0, tag, "chip-select activity", cs_falls - f0, 0);
      exp_q.delete();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", "run timed out", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(req_ready == 1'b1, "R12", "req_ready", int'(req_ready), 1);
      chk(spi_cs_n == 1'b1, "R12", "spi_cs_n", int'(spi_cs_n), 1);
      chk(out_valid == 1'b0 && done == 1'b0, "R12", "valid/done", int'(out_valid | done), 0);

      // R1 R4 mid-page read
      do_read(5 * 2048 + 10, 4, 0, 0, 1, 1, "R1_R4");
      // R5 same row, no load
      do_read(5 * 2048 + 100, 3, 0, 0, 0, 1, "R5");
      // R7 crossing into the next row
      do_read(8 * 2048 + 2046, 4, 0, 0, 2, 1, "R7");
      do_read(9 * 2048, 2, 0, 0, 0, 1, "R5_after_cross");
      // R3 corrected
      ecc_cfg = 2'd1;
      do_read(20 * 2048, 3, 0, 1, 1, 1, "R3_corrected");
      // R3 uncorrectable, R6 reload after it
      ecc_cfg = 2'd2;
      do_read(30 * 2048 + 7, 2, 0, 2, 1, 1, "R3_uncorrectable");
      ecc_cfg = 2'd0;
      do_read(30 * 2048 + 7, 2, 0, 0, 1, 1, "R6_after_uncorr");
      // R2 timeout, R6 reload after it
      busy_cfg = 250;
      do_read(40 * 2048, 1, 0, 3, 1, 1, "R2_timeout");
      busy_cfg = 3;
      do_read(40 * 2048, 1, 0, 0, 1, 1, "R6_after_timeout");
      // R2 last poll succeeds
      busy_cfg = 199;
      do_read(41 * 2048 + 5, 2, 0, 0, 1, 1, "R2_last_poll");
      busy_cfg = 3;
      // R8 bad block needing a load, then bad flag on a cached row
      do_read(320 * 2048, 2, 1, 4, 0, 0, "R8_bad");
      do_read(41 * 2048 + 9, 2, 1, 0, 0, 1, "R8_cached");
      // R6 flush input
      @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
      do_read(41 * 2048 + 9, 2, 0, 0, 1, 1, "R6_flush");
      // R9 range
      do_read((1 << 27) - 2, 4, 0, 5, 0, 0, "R9_over");
      do_read((1 << 27) - 2, 2, 0, 0, 1, 1, "R9_exact_end");
      do_read((1 << 27) - 2, 1, 0, 0, 0, 1, "R6_allones_row_cached");
      // R10 zero length
      do_read(77 * 2048, 0, 0, 0, 0, 0, "R10");
      // R11 backpressure across a page boundary
      stall_mode = 1'b1;
      do_read(100 * 2048 + 2040, 16, 0, 0, 2, 1, "R11_R7_stall");
      stall_mode = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule